// File: doc/BRIEF.md
# Prioritized Interrupt Entry Controller

This block decides, once per clock cycle, whether the interrupt level presented to the processor may be taken. When it is taken, the block performs the matching processor-state update. A level is taken only when three things hold: it outranks the current status level, it is within the configured number of levels, and at least one of its sources is both raised and enabled. The block then saves the interrupted program counter and status word, rewrites the status word, and produces the new program counter.

Levels above 1 each own a saved-PC slot, a saved-status slot and a vector. Level 1 takes a different path: it becomes a general exception, and the cause register records the level-1-interrupt code. The exception is of user, kernel or double class, and it goes to the vector of that class. Every vector can be moved at run time through a base register, or kept at its static address, depending on a parameter.

All updates and the one-cycle `taken` pulse occur together. No new request is accepted in the cycle in which `taken` is high.

Top module: `irq_entry_ctl`

## Requirements
- R1: A request at level L is taken only when L is strictly greater than `cur_ps_level`, L is no greater than NLEVEL (default 4), and (mask of L AND `int_set` AND `int_en`) is nonzero. Level 0 is never taken. Default masks: level 1 = 0x03, level 2 = 0x04, level 3 = 0x08, level 4 = 0x30, level 5 = 0x40, level 6 = 0x80.
- R2: On a take at level L > 1, the current PC is stored in `save_pc` slot L-1 (bits [(L-1)*32 +: 32]). The current status word is stored in `save_ps` slot L-2 (bits [(L-2)*6 +: 6]). A status word is {um, excm, level[3:0]}, with the level in bits [3:0], excm in bit 4 and um in bit 5.
- R3: On a take at level L > 1, the new status has level L and excm set, and um is kept. `new_pc` is that level's vector, which by default is the vector base + 0x180 + (L-2)*0x40. `exc_class` reads 0.
- R4: A level-1 take loads `cause` with 4. A take at a higher level leaves `cause` unchanged.
- R5: A level-1 take with excm clear stores the PC in `save_pc` slot 0. The class is user (1), with vector base + 0x340, when um is set. Otherwise the class is kernel (2), with vector base + 0x300.
- R6: A level-1 take with excm set is a double exception: class 3, vector base + 0x3C0. The PC goes to `dbl_pc` when HAS_DBL_PC is 1, and otherwise to `save_pc` slot 0.
- R7: A level-1 take sets excm and keeps the current level and um bits in the new status.
- R8: With RELOC_EN = 1, each target is the static vector minus STATIC_BASE (default 0x4000_0000) plus `vec_base`. With RELOC_EN = 0, the static vector is used.
- R9: All updates are registered one cycle after the request. `taken` is a one-cycle pulse, and a request held during the pulse is not taken in that cycle.
- R10: After reset, `taken`, `exc_class`, `new_pc`, `new_ps_*`, `cause`, `dbl_pc` and all save slots are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_level | input | 3 | Pending interrupt level |
| int_set | input | NUM_INT | Raised interrupt sources |
| int_en | input | NUM_INT | Enabled interrupt sources |
| cur_pc | input | 32 | Program counter at the point of interruption |
| cur_ps_level | input | 4 | Current status interrupt level |
| cur_ps_excm | input | 1 | Current exception-mode bit |
| cur_ps_um | input | 1 | Current user-mode bit |
| vec_base | input | 32 | Run-time vector base |
| taken | output | 1 | One-cycle pulse on entry |
| exc_class | output | 2 | 0 high level, 1 user, 2 kernel, 3 double |
| new_pc | output | 32 | Target program counter |
| new_ps_level | output | 4 | New status level |
| new_ps_excm | output | 1 | New exception-mode bit |
| new_ps_um | output | 1 | New user-mode bit |
| save_pc | output | NLEVEL*32 | Saved-PC slots, level 1 in slot 0 |
| save_ps | output | (NLEVEL-1)*6 | Saved-status slots, level 2 in slot 0 |
| dbl_pc | output | 32 | Double-exception saved PC |
| cause | output | 6 | Exception cause |

## Verification
A wrong acceptance decision appears one cycle after the request. It shows as `taken` rising when it should stay low, or staying low when it should rise. A wrong slot index or a wrong class decision is just as quick to see: the stored PC lands in a neighbouring `save_pc` slot, or `exc_class` and `new_pc` point at the wrong vector, on the same edge. The bench exercises every take path and the boundaries of the acceptance rule. A second instance, built without relocation and without a double-exception PC register, exposes both parameter variants at the ports.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int PS_W    = 6;
    localparam int CAUSE_W = 6;
    localparam int LVL_W   = 3;
    localparam int PSL_W   = 4;
    localparam int MAX_LVL = 7;

    // status word: {um, excm, level}
    typedef struct packed {
        logic             um;
        logic             excm;
        logic [PSL_W-1:0] level;
    } ps_t;

    typedef enum logic [1:0] {
        CLS_HIGH   = 2'd0,
        CLS_USER   = 2'd1,
        CLS_KERNEL = 2'd2,
        CLS_DOUBLE = 2'd3
    } cls_e;

endpackage

// File: rtl/irq_entry_gate.sv
module irq_entry_gate
    import irq_entry_pkg::*;
#(
    parameter int                         NUM_INT    = 8,
    parameter int                         NLEVEL     = 4,
    parameter logic [MAX_LVL*NUM_INT-1:0] LEVEL_MASK = '0
) (
    input  logic [LVL_W-1:0]   irq_level,
    input  logic [PSL_W-1:0]   cur_level,
    input  logic [NUM_INT-1:0] int_set,
    input  logic [NUM_INT-1:0] int_en,
    input  logic               blocked,
    output logic               accept
);

    logic [NUM_INT-1:0] lvl_mask;
    logic               above_cur;
    logic               in_range;
    logic               src_hit;

    // select the source mask of the requested level
    always_comb begin
        lvl_mask = '0;
        for (int l = 0; l < MAX_LVL; l++) begin
            if (irq_level == LVL_W'(l)) begin
                lvl_mask = LEVEL_MASK[l*NUM_INT +: NUM_INT];
            end
        end
    end

    assign above_cur = {1'b0, irq_level} > cur_level;
    assign in_range  = irq_level <= LVL_W'(NLEVEL);
    assign src_hit   = |(lvl_mask & int_set & int_en);
    assign accept    = !blocked && above_cur && in_range && src_hit;

endmodule

// File: rtl/irq_entry_vec.sv
module irq_entry_vec #(
    parameter bit          RELOC_EN    = 1'b1,
    parameter logic [31:0] STATIC_BASE = 32'h4000_0000
) (
    input  logic [31:0] static_vec,
    input  logic [31:0] vec_base,
    output logic [31:0] target
);

    generate
        if (RELOC_EN) begin : g_reloc
            assign target = static_vec - STATIC_BASE + vec_base;
        end else begin : g_fixed
            logic [31:0] unused_base;
            assign unused_base = vec_base;
            assign target      = static_vec;
        end
    endgenerate

endmodule

// File: rtl/irq_entry_ctl.sv
module irq_entry_ctl
    import irq_entry_pkg::*;
#(
    parameter int                         NUM_INT       = 8,
    parameter int                         NLEVEL        = 4,
    parameter bit                         HAS_DBL_PC    = 1'b1,
    parameter bit                         RELOC_EN      = 1'b1,
    parameter logic [MAX_LVL*NUM_INT-1:0] LEVEL_MASK    = 56'h80_40_30_08_04_03_00,
    parameter logic [31:0]                STATIC_BASE   = 32'h4000_0000,
    parameter logic [31:0]                HI_VEC_OFS    = 32'h0000_0180,
    parameter logic [31:0]                HI_VEC_STRIDE = 32'h0000_0040,
    parameter logic [31:0]                KERNEL_OFS    = 32'h0000_0300,
    parameter logic [31:0]                USER_OFS      = 32'h0000_0340,
    parameter logic [31:0]                DOUBLE_OFS    = 32'h0000_03C0,
    parameter logic [CAUSE_W-1:0]         LVL1_CAUSE    = 6'd4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 irq_level,
    input  logic [NUM_INT-1:0]         int_set,
    input  logic [NUM_INT-1:0]         int_en,
    input  logic [31:0]                cur_pc,
    input  logic [3:0]                 cur_ps_level,
    input  logic                       cur_ps_excm,
    input  logic                       cur_ps_um,
    input  logic [31:0]                vec_base,
    output logic                       taken,
    output logic [1:0]                 exc_class,
    output logic [31:0]                new_pc,
    output logic [3:0]                 new_ps_level,
    output logic                       new_ps_excm,
    output logic                       new_ps_um,
    output logic [NLEVEL*32-1:0]       save_pc,
    output logic [(NLEVEL-1)*PS_W-1:0] save_ps,
    output logic [31:0]                dbl_pc,
    output logic [5:0]                 cause
);

    typedef struct packed {
        logic [31:0]                   pc;
        ps_t                           ps;
        logic [NLEVEL-1:0][31:0]       epc;
        logic [NLEVEL-2:0][PS_W-1:0]   eps;
        logic [31:0]                   dpc;
        logic [CAUSE_W-1:0]            cause;
        logic                          taken;
        logic [1:0]                    cls;
    } state_t;

    state_t      st_d, st_q;
    ps_t         cur_ps;
    logic        accept;
    logic [31:0] static_vec;
    logic [31:0] target;

    assign cur_ps = {cur_ps_um, cur_ps_excm, cur_ps_level};

    irq_entry_gate #(
        .NUM_INT    (NUM_INT),
        .NLEVEL     (NLEVEL),
        .LEVEL_MASK (LEVEL_MASK)
    ) i_gate (
        .irq_level (irq_level),
        .cur_level (cur_ps_level),
        .int_set   (int_set),
        .int_en    (int_en),
        .blocked   (st_q.taken),
        .accept    (accept)
    );

    // static vector for the path this request would take
    always_comb begin
        if (irq_level > 3'd1) begin
            static_vec = STATIC_BASE + HI_VEC_OFS
                       + (32'(irq_level) - 32'd2) * HI_VEC_STRIDE;
        end else if (cur_ps_excm) begin
            static_vec = STATIC_BASE + DOUBLE_OFS;
        end else if (cur_ps_um) begin
            static_vec = STATIC_BASE + USER_OFS;
        end else begin
            static_vec = STATIC_BASE + KERNEL_OFS;
        end
    end

    irq_entry_vec #(
        .RELOC_EN    (RELOC_EN),
        .STATIC_BASE (STATIC_BASE)
    ) i_vec (
        .static_vec (static_vec),
        .vec_base   (vec_base),
        .target     (target)
    );

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        st_d.cls   = CLS_HIGH;
        if (accept) begin
            st_d.taken = 1'b1;
            st_d.pc    = target;
            if (irq_level > 3'd1) begin
                for (int l = 2; l <= NLEVEL; l++) begin
                    if (irq_level == LVL_W'(l)) begin
                        st_d.epc[l-1] = cur_pc;
                        st_d.eps[l-2] = cur_ps;
                    end
                end
                st_d.ps.level = {1'b0, irq_level};
                st_d.ps.excm  = 1'b1;
                st_d.ps.um    = cur_ps_um;
            end else begin
                st_d.cause = LVL1_CAUSE;
                if (cur_ps_excm) begin
                    st_d.cls = CLS_DOUBLE;
                    if (HAS_DBL_PC) begin
                        st_d.dpc = cur_pc;
                    end else begin
                        st_d.epc[0] = cur_pc;
                    end
                end else begin
                    st_d.epc[0] = cur_pc;
                    st_d.cls    = cur_ps_um ? CLS_USER : CLS_KERNEL;
                end
                st_d.ps      = cur_ps;
                st_d.ps.excm = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign taken        = st_q.taken;
    assign exc_class    = st_q.cls;
    assign new_pc       = st_q.pc;
    assign new_ps_level = st_q.ps.level;
    assign new_ps_excm  = st_q.ps.excm;
    assign new_ps_um    = st_q.ps.um;
    assign save_pc      = st_q.epc;
    assign save_ps      = st_q.eps;
    assign dbl_pc       = st_q.dpc;
    assign cause        = st_q.cause;

endmodule

module irq_entry_ctl_chk #(
    parameter logic [5:0] LVL1_CAUSE = 6'd4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] irq_level,
    input logic [3:0] cur_ps_level,
    input logic       cur_ps_excm,
    input logic       cur_ps_um,
    input logic       taken,
    input logic [1:0] exc_class,
    input logic [3:0] new_ps_level,
    input logic       new_ps_excm,
    input logic       new_ps_um,
    input logic [5:0] cause
);

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> !taken);

    assert_level_above_R1: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> ({1'b0, $past(irq_level)} > $past(cur_ps_level)));

    assert_excm_on_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> new_ps_excm);

    assert_high_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && exc_class == 2'd0) |-> (new_ps_level == {1'b0, $past(irq_level)}));

    assert_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && exc_class != 2'd0) |-> (cause == LVL1_CAUSE));

    assert_double_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && exc_class == 2'd3) |-> $past(cur_ps_excm));

    assert_user_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && exc_class == 2'd1) |-> ($past(cur_ps_um) && !$past(cur_ps_excm)));

    assert_um_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (new_ps_um == $past(cur_ps_um)));

endmodule

bind irq_entry_ctl irq_entry_ctl_chk #(.LVL1_CAUSE(LVL1_CAUSE)) i_chk (.*);

// File: tb/test_irq_entry_ctl.sv
`timescale 1ns/1ps
module test_irq_entry_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  irq_level = '0;
    logic [7:0]  int_set = '0;
    logic [7:0]  int_en = '0;
    logic [31:0] cur_pc = '0;
    logic [3:0]  cur_ps_level = '0;
    logic        cur_ps_excm = 1'b0;
    logic        cur_ps_um = 1'b0;
    logic [31:0] vec_base = 32'h4000_0000;

    logic        taken, a_taken;
    logic [1:0]  exc_class, a_exc_class;
    logic [31:0] new_pc, a_new_pc;
    logic [3:0]  new_ps_level, a_new_ps_level;
    logic        new_ps_excm, a_new_ps_excm, new_ps_um, a_new_ps_um;
    logic [127:0] save_pc, a_save_pc;
    logic [17:0] save_ps, a_save_ps;
    logic [31:0] dbl_pc, a_dbl_pc;
    logic [5:0]  cause, a_cause;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_entry_ctl i_irq_entry_ctl (
        .clk, .rst_n, .irq_level, .int_set, .int_en, .cur_pc,
        .cur_ps_level, .cur_ps_excm, .cur_ps_um, .vec_base,
        .taken, .exc_class, .new_pc, .new_ps_level, .new_ps_excm,
        .new_ps_um, .save_pc, .save_ps, .dbl_pc, .cause
    );

    irq_entry_ctl #(.HAS_DBL_PC(1'b0), .RELOC_EN(1'b0)) i_irq_entry_ctl_alt (
        .clk, .rst_n, .irq_level, .int_set, .int_en, .cur_pc,
        .cur_ps_level, .cur_ps_excm, .cur_ps_um, .vec_base,
        .taken(a_taken), .exc_class(a_exc_class), .new_pc(a_new_pc),
        .new_ps_level(a_new_ps_level), .new_ps_excm(a_new_ps_excm),
        .new_ps_um(a_new_ps_um), .save_pc(a_save_pc), .save_ps(a_save_ps),
        .dbl_pc(a_dbl_pc), .cause(a_cause)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [5:0] ps_now();
        return {new_ps_um, new_ps_excm, new_ps_level};
    endfunction

    // present a request at a falling edge; results are read one cycle later
    task automatic drive(input logic [2:0] lvl, input logic [7:0] s, input logic [7:0] e,
                         input logic [31:0] pc, input logic [3:0] psl,
                         input logic excm, input logic um);
        @(negedge clk);
        irq_level    = lvl;
        int_set      = s;
        int_en       = e;
        cur_pc       = pc;
        cur_ps_level = psl;
        cur_ps_excm  = excm;
        cur_ps_um    = um;
        @(negedge clk);
    endtask

    task automatic release_req();
        irq_level = '0;
        int_set   = '0;
        int_en    = '0;
    endtask

    task automatic t_reset();
        check("R10 taken after reset", 32'(taken), 0);
        check("R10 new_pc after reset", new_pc, 0);
        check("R10 status after reset", 32'(ps_now()), 0);
        check("R10 cause after reset", 32'(cause), 0);
        check("R10 class after reset", 32'(exc_class), 0);
        check("R10 slots after reset", save_pc[31:0] | save_pc[127:96] | 32'(save_ps), 0);
    endtask

    task automatic t_level2();
        drive(3'd2, 8'h04, 8'h04, 32'h1000, 4'd0, 1'b0, 1'b1);
        check("R1 level2 taken", 32'(taken), 1);
        check("R3 level2 vector", new_pc, 32'h4000_0180);
        check("R3 level2 status", 32'(ps_now()), 32'h32);
        check("R3 level2 class", 32'(exc_class), 0);
        check("R2 level2 saved pc", save_pc[63:32], 32'h1000);
        check("R2 level2 saved status", 32'(save_ps[5:0]), 32'h20);
        check("R4 cause untouched by level2", 32'(cause), 0);
        release_req();
    endtask

    task automatic t_reject();
        drive(3'd2, 8'h04, 8'h04, 32'h5000, 4'd2, 1'b0, 1'b0);
        check("R1 level equal to current rejected", 32'(taken), 0);
        release_req();
        drive(3'd5, 8'h40, 8'h40, 32'h5000, 4'd0, 1'b0, 1'b0);
        check("R1 level above NLEVEL rejected", 32'(taken), 0);
        release_req();
        drive(3'd3, 8'h08, 8'h00, 32'h5000, 4'd0, 1'b0, 1'b0);
        check("R1 disabled source rejected", 32'(taken), 0);
        release_req();
        drive(3'd3, 8'h04, 8'h04, 32'h5000, 4'd0, 1'b0, 1'b0);
        check("R1 source of other level rejected", 32'(taken), 0);
        release_req();
        drive(3'd1, 8'h01, 8'h01, 32'h5000, 4'd1, 1'b0, 1'b0);
        check("R1 level1 at current level1 rejected", 32'(taken), 0);
        release_req();
        drive(3'd0, 8'hFF, 8'hFF, 32'h5000, 4'd0, 1'b0, 1'b0);
        check("R1 level0 rejected", 32'(taken), 0);
        check("R1 state held after rejects", new_pc, 32'h4000_0180);
        check("R1 slots held after rejects", save_pc[63:32], 32'h1000);
        release_req();
    endtask

    task automatic t_level4();
        drive(3'd4, 8'h20, 8'hFF, 32'h2000, 4'd1, 1'b1, 1'b0);
        check("R1 level4 taken", 32'(taken), 1);
        check("R3 level4 vector", new_pc, 32'h4000_0200);
        check("R3 level4 status", 32'(ps_now()), 32'h14);
        check("R2 level4 saved pc", save_pc[127:96], 32'h2000);
        check("R2 level4 saved status", 32'(save_ps[17:12]), 32'h11);
        check("R2 level2 slot kept", save_pc[63:32], 32'h1000);
        release_req();
    endtask

    task automatic t_kernel();
        drive(3'd1, 8'h01, 8'h01, 32'h3000, 4'd0, 1'b0, 1'b0);
        check("R5 kernel taken", 32'(taken), 1);
        check("R5 kernel class", 32'(exc_class), 2);
        check("R5 kernel vector", new_pc, 32'h4000_0300);
        check("R5 kernel saved pc", save_pc[31:0], 32'h3000);
        check("R4 level1 cause", 32'(cause), 4);
        check("R7 kernel status", 32'(ps_now()), 32'h10);
        release_req();
    endtask

    task automatic t_user();
        drive(3'd1, 8'h02, 8'h02, 32'h3100, 4'd0, 1'b0, 1'b1);
        check("R5 user class", 32'(exc_class), 1);
        check("R5 user vector", new_pc, 32'h4000_0340);
        check("R5 user saved pc", save_pc[31:0], 32'h3100);
        check("R7 user status", 32'(ps_now()), 32'h30);
        release_req();
    endtask

    task automatic t_double();
        drive(3'd1, 8'h01, 8'h01, 32'h3200, 4'd0, 1'b1, 1'b1);
        check("R6 double class", 32'(exc_class), 3);
        check("R6 double vector", new_pc, 32'h4000_03C0);
        check("R6 double pc register", dbl_pc, 32'h3200);
        check("R6 level1 slot kept with double reg", save_pc[31:0], 32'h3100);
        check("R7 double status", 32'(ps_now()), 32'h30);
        check("R6 no double reg uses level1 slot", a_save_pc[31:0], 32'h3200);
        check("R6 no double reg leaves dbl_pc", a_dbl_pc, 32'h0);
        check("R6 no double reg class", 32'(a_exc_class), 3);
        release_req();
    endtask

    task automatic t_reloc();
        vec_base = 32'h8000_0000;
        drive(3'd3, 8'h08, 8'h08, 32'h4000, 4'd0, 1'b0, 1'b0);
        check("R8 relocated level3 vector", new_pc, 32'h8000_01C0);
        check("R8 fixed level3 vector", a_new_pc, 32'h4000_01C0);
        release_req();
        drive(3'd1, 8'h01, 8'h01, 32'h4100, 4'd0, 1'b0, 1'b0);
        check("R8 relocated kernel vector", new_pc, 32'h8000_0300);
        check("R8 fixed kernel vector", a_new_pc, 32'h4000_0300);
        release_req();
        vec_base = 32'h4000_0000;
    endtask

    task automatic t_blocking();
        drive(3'd2, 8'h04, 8'h04, 32'h6000, 4'd0, 1'b0, 1'b0);
        check("R9 first take", 32'(taken), 1);
        @(negedge clk);
        check("R9 held request blocked during pulse", 32'(taken), 0);
        @(negedge clk);
        check("R9 held request taken again", 32'(taken), 1);
        check("R9 second take vector", new_pc, 32'h4000_0180);
        release_req();
        @(negedge clk);
        check("R9 pulse ends", 32'(taken), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level2();
        t_reject();
        t_level4();
        t_kernel();
        t_user();
        t_double();
        t_reloc();
        t_blocking();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule